// File: doc/BRIEF.md
# I2S Transmit Serializer

This block turns audio samples from an upstream transmit FIFO into a serial I2S stream. It drives a bit clock (`bclk_o`), a word-select line and a serial data line. It runs on the system clock. The bit clock is produced by dividing that clock by a fixed parameter. Data and word select change only on falling bit-clock edges, so a receiver samples them on rising edges.

A small set of control pins sets how the stream is formatted:
- sample size in bytes;
- mono or stereo;
- master or slave framing;
- the word-select half period;
- mute, stop and soft reset, which are three separate controls.

In master mode the block counts bit clocks and toggles word select on its own. In slave mode it synchronizes an external word-select input and follows it.

Each word is sent MSB first, starting one bit clock after the word-select edge that opens its half frame. Bit positions left over in the half frame carry zeros.

Samples arrive on a valid/ready stream:
- `s_ready` goes high for exactly one system-clock cycle when a new word is due.
- A transfer happens only in a cycle where `s_valid` and `s_ready` are both high.
- The upstream side may raise or hold `s_valid` at any time. Nothing is taken while `s_ready` is low.
- If `s_valid` is low in the one cycle that `s_ready` is high, the block does not wait. It sends a zero word instead and raises a sticky underrun flag.

Top module: `i2s_tx_serializer`

## Requirements
- R1: `cfg_width` selects the sample size, taken from the low bits of `s_data`: 2'b00 = 8 bits, 2'b01 = 16 bits, 2'b10 and 2'b11 = 32 bits. Bits of `s_data` above the sample size are ignored.
- R2: Each word is sent MSB first on `sd_o`. Its MSB is the bit sampled on the second rising bit-clock edge after word select changes. The bit sampled on the rising edge where the change is first seen still belongs to the previous half frame. Positions after the word are zero. If the half frame is shorter than the word, the word is cut after its first (half-frame-length) bits.
- R3: Word select low is the left channel and high is the right channel. The first half frame after reset is the left channel. In stereo (`cfg_mono`=0) each half frame takes a new sample, so samples alternate left, right. In mono (`cfg_mono`=1) one sample is taken per left half frame and sent again on the following right half frame.
- R4: With `cfg_slave`=0 the block drives word select (`ws_oe`=1) and toggles it every `cfg_half_period`+1 bit clocks.
- R5: With `cfg_slave`=1, `ws_oe`=0 and framing follows `ws_i`. The bench relies on half frames on `ws_o` lasting as many bit clocks as `ws_i` holds each level, and on `cfg_half_period` having no effect.
- R6: With `cfg_mute`=1, `sd_o` stays zero while framing runs and words are still taken from the stream.
- R7: With `cfg_stop`=1, `s_ready` stays low, `sd_o` stays zero and no underrun is flagged.
- R8: If a word is due and `s_valid` is low, zeros are sent for that half frame and `underrun` goes to 1. It stays at 1 until a reset, even after data arrives.
- R9: `cfg_soft_rst`=1 clears the channel state asynchronously, with `underrun`, `bclk_o` and `sd_o` at 0. It also drives `fifo_flush`=1 so that the upstream FIFO is emptied.
- R10: `s_ready` is high for at most one cycle per word. That cycle is the one that ends with a falling bit-clock edge.
- R11: After reset: `bclk_o`=0, `sd_o`=0, `s_ready`=0, `underrun`=0 and `ws_o`=1. `ws_oe` equals the inverse of `cfg_slave`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | 2 | Sample size code |
| cfg_mono | input | 1 | 1 = one sample on both channels |
| cfg_stop | input | 1 | 1 = stop taking words, send zeros |
| cfg_soft_rst | input | 1 | 1 = asynchronous clear of the channel |
| cfg_slave | input | 1 | 0 = drive word select, 1 = follow `ws_i` |
| cfg_half_period | input | HP_W | Bit clocks per half frame, minus one |
| cfg_mute | input | 1 | 1 = send zeros, keep taking words |
| s_data | input | 32 | Sample from the FIFO |
| s_valid | input | 1 | FIFO holds a sample |
| s_ready | output | 1 | Word is taken this cycle if valid |
| fifo_flush | output | 1 | Clear request to the upstream FIFO |
| bclk_o | output | 1 | Bit clock |
| ws_o | output | 1 | Word select |
| ws_oe | output | 1 | Drive enable for word select |
| ws_i | input | 1 | External word select (slave mode) |
| sd_o | output | 1 | Serial data |
| underrun | output | 1 | Sticky empty-FIFO flag |

## Verification
The bench builds the block with its defaults: a 9-bit half-period field, two system clocks per bit-clock phase and a two-stage word-select synchronizer.

The short bit clock (four system clocks) keeps frames of 16 to 64 bit clocks within a few hundred cycles. This leaves room for several frames in each of the following cases:
- stereo and mono;
- each sample size, including the redundant 32-bit code;
- a half frame shorter than the word;
- mute, stop and underrun;
- slave framing.

The two-stage synchronizer makes the slave lag constant. That lets the bench compare half-frame lengths on `ws_o` against the period it drives on `ws_i`.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  localparam int SAMPLE_W = 32;

  typedef enum logic [1:0] {
    WID_8   = 2'b00,
    WID_16  = 2'b01,
    WID_32A = 2'b10,
    WID_32  = 2'b11
  } width_e;

  // Left-align the active sample bits so the MSB leaves first.
  function automatic logic [SAMPLE_W-1:0] align_word(width_e w, logic [SAMPLE_W-1:0] d);
    logic [SAMPLE_W-1:0] r;
    case (w)
      WID_8:   r = {d[7:0], 24'h0};
      WID_16:  r = {d[15:0], 16'h0};
      default: r = d;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/i2s_tx_bclk_gen.sv
module i2s_tx_bclk_gen #(
  parameter int BCLK_HALF = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic bclk_o,
  output logic step_o
);
  localparam int DIV_W = (BCLK_HALF > 1) ? $clog2(BCLK_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(BCLK_HALF - 1);

  logic [DIV_W-1:0] div_q;
  logic             bclk_q;
  logic             tick;

  assign tick = (div_q == DIV_LAST);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      div_q  <= '0;
      bclk_q <= 1'b0;
    end else if (tick) begin
      div_q  <= '0;
      bclk_q <= ~bclk_q;
    end else begin
      div_q  <= div_q + 1'b1;
    end
  end

  assign bclk_o = bclk_q;
  // A step is the cycle that ends with the bit clock falling.
  assign step_o = tick & bclk_q;
endmodule

// File: rtl/i2s_tx_framer.sv
module i2s_tx_framer #(
  parameter int HP_W        = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            arst_n,
  input  logic            step_i,
  input  logic            slave_i,
  input  logic [HP_W-1:0] half_period_i,
  input  logic            ws_ext_i,
  output logic            ws_o,
  output logic            edge_o,
  output logic            chan_o
);
  logic            ws_sync;
  logic            ws_q;
  logic            ws_next;
  logic [HP_W-1:0] bit_cnt_q;
  logic            wrap;

  generate
    if (SYNC_STAGES <= 1) begin : g_sync1
      logic s_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) s_q <= 1'b1;
        else         s_q <= ws_ext_i;
      end
      assign ws_sync = s_q;
    end else begin : g_syncn
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) s_q <= '1;
        else         s_q <= {s_q[SYNC_STAGES-2:0], ws_ext_i};
      end
      assign ws_sync = s_q[SYNC_STAGES-1];
    end
  endgenerate

  assign wrap    = (bit_cnt_q == half_period_i);
  assign ws_next = slave_i ? ws_sync : (wrap ? ~ws_q : ws_q);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      ws_q      <= 1'b1;
      bit_cnt_q <= '0;
    end else if (step_i) begin
      ws_q      <= ws_next;
      bit_cnt_q <= wrap ? '0 : bit_cnt_q + 1'b1;
    end
  end

  assign ws_o   = ws_q;
  assign edge_o = step_i & (ws_next != ws_q);
  assign chan_o = ws_next;
endmodule

// File: rtl/i2s_tx_shifter.sv
module i2s_tx_shifter
  import i2s_tx_pkg::*;
(
  input  logic                clk,
  input  logic                arst_n,
  input  logic                step_i,
  input  logic                edge_i,
  input  logic                chan_i,
  input  width_e              width_i,
  input  logic                mono_i,
  input  logic                stop_i,
  input  logic                mute_i,
  input  logic [SAMPLE_W-1:0] s_data_i,
  input  logic                s_valid_i,
  output logic                s_ready_o,
  output logic                sd_o,
  output logic                underrun_o
);
  logic [SAMPLE_W-1:0] sr_q;
  logic [SAMPLE_W-1:0] held_q;
  logic [SAMPLE_W-1:0] aligned;
  logic [SAMPLE_W-1:0] load;
  logic                need_pop;
  logic                take;
  logic                sd_q;
  logic                undr_q;

  assign aligned = align_word(width_i, s_data_i);

  always_comb begin
    need_pop = ~(mono_i & chan_i);
    take     = edge_i & need_pop & ~stop_i;
    if (stop_i)          load = '0;
    else if (!need_pop)  load = held_q;
    else if (s_valid_i)  load = aligned;
    else                 load = '0;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sr_q   <= '0;
      held_q <= '0;
      sd_q   <= 1'b0;
      undr_q <= 1'b0;
    end else begin
      if (step_i) begin
        // On a frame edge the old LSB still leaves; the new word follows.
        sd_q <= (mute_i | stop_i) ? 1'b0 : sr_q[SAMPLE_W-1];
        sr_q <= edge_i ? load : {sr_q[SAMPLE_W-2:0], 1'b0};
      end
      if (take && s_valid_i)  held_q <= aligned;
      if (take && !s_valid_i) undr_q <= 1'b1;
    end
  end

  assign s_ready_o  = take;
  assign sd_o       = sd_q;
  assign underrun_o = undr_q;
endmodule

// File: rtl/i2s_tx_serializer.sv
module i2s_tx_serializer
  import i2s_tx_pkg::*;
#(
  parameter int HP_W        = 9,
  parameter int BCLK_HALF   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cfg_width,
  input  logic                cfg_mono,
  input  logic                cfg_stop,
  input  logic                cfg_soft_rst,
  input  logic                cfg_slave,
  input  logic [HP_W-1:0]     cfg_half_period,
  input  logic                cfg_mute,
  input  logic [SAMPLE_W-1:0] s_data,
  input  logic                s_valid,
  output logic                s_ready,
  output logic                fifo_flush,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                ws_oe,
  input  logic                ws_i,
  output logic                sd_o,
  output logic                underrun
);
  logic arst_n;
  logic bit_step;
  logic frame_edge;
  logic chan;

  assign arst_n     = rst_n & ~cfg_soft_rst;
  assign fifo_flush = cfg_soft_rst;
  assign ws_oe      = ~cfg_slave;

  i2s_tx_bclk_gen #(.BCLK_HALF(BCLK_HALF)) u_bclk (
    .clk    (clk),
    .arst_n (arst_n),
    .bclk_o (bclk_o),
    .step_o (bit_step)
  );

  i2s_tx_framer #(.HP_W(HP_W), .SYNC_STAGES(SYNC_STAGES)) u_framer (
    .clk           (clk),
    .arst_n        (arst_n),
    .step_i        (bit_step),
    .slave_i       (cfg_slave),
    .half_period_i (cfg_half_period),
    .ws_ext_i      (ws_i),
    .ws_o          (ws_o),
    .edge_o        (frame_edge),
    .chan_o        (chan)
  );

  i2s_tx_shifter u_shift (
    .clk        (clk),
    .arst_n     (arst_n),
    .step_i     (bit_step),
    .edge_i     (frame_edge),
    .chan_i     (chan),
    .width_i    (width_e'(cfg_width)),
    .mono_i     (cfg_mono),
    .stop_i     (cfg_stop),
    .mute_i     (cfg_mute),
    .s_data_i   (s_data),
    .s_valid_i  (s_valid),
    .s_ready_o  (s_ready),
    .sd_o       (sd_o),
    .underrun_o (underrun)
  );
endmodule

// File: rtl/i2s_tx_serializer_chk.sv
module i2s_tx_serializer_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic step,
  input logic bclk,
  input logic ws,
  input logic sd,
  input logic s_ready,
  input logic mute,
  input logic stop,
  input logic underrun
);
  // R10: a word is offered for one cycle only
  a_r10_ready_single: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    s_ready |=> !s_ready);

  // R10: the offer lines up with a falling bit clock
  a_r10_ready_at_fall: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    s_ready |=> $fell(bclk));

  // R4: word select only moves on a falling bit clock
  a_r4_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    !$stable(ws) |-> $fell(bclk));

  // R2: data only moves on a falling bit clock
  a_r2_sd_on_fall: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    !$stable(sd) |-> $fell(bclk));

  // R6 and R7: a bit sent while muted or stopped is zero
  a_r6_quiet_zero: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    (step && (mute || stop)) |=> !sd);

  // R8: underrun holds until reset
  a_r8_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n || soft_rst)
    underrun |=> underrun);
endmodule

bind i2s_tx_serializer i2s_tx_serializer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .soft_rst (cfg_soft_rst),
  .step     (bit_step),
  .bclk     (bclk_o),
  .ws       (ws_o),
  .sd       (sd_o),
  .s_ready  (s_ready),
  .mute     (cfg_mute),
  .stop     (cfg_stop),
  .underrun (underrun)
);

// File: tb/i2s_tx_serializer_test.sv
module i2s_tx_serializer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_width = 2'b01;
  logic        cfg_mono = 1'b0, cfg_stop = 1'b0, cfg_soft_rst = 1'b0;
  logic        cfg_slave = 1'b1, cfg_mute = 1'b1;
  logic [8:0]  cfg_half_period = 9'd31;
  logic [31:0] s_data = '0;
  logic        s_valid = 1'b0;
  logic        ws_i = 1'b1;
  logic        s_ready, fifo_flush, bclk_o, ws_o, ws_oe, sd_o, underrun;

  always #2 clk = ~clk;

  i2s_tx_serializer uut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_mono(cfg_mono),
    .cfg_stop(cfg_stop), .cfg_soft_rst(cfg_soft_rst), .cfg_slave(cfg_slave),
    .cfg_half_period(cfg_half_period), .cfg_mute(cfg_mute), .s_data(s_data),
    .s_valid(s_valid), .s_ready(s_ready), .fifo_flush(fifo_flush), .bclk_o(bclk_o),
    .ws_o(ws_o), .ws_oe(ws_oe), .ws_i(ws_i), .sd_o(sd_o), .underrun(underrun)
  );

  int n_chk = 0, n_fail = 0;

  // Source FIFO model
  logic [31:0] q_mem [0:15];
  int  q_cnt = 0, q_head = 0;
  bit  pend = 0;

  always @(negedge clk) begin
    if (pend) begin q_head++; pend = 0; end
    s_valid = (q_head < q_cnt);
    s_data  = s_valid ? q_mem[q_head] : 32'h0;
    if (s_ready && s_valid) pend = 1;
  end

  // I2S receiver model, sampling on rising bit clock
  logic [63:0] fr_bits [0:31];
  int          fr_len  [0:31];
  bit          fr_ws   [0:31];
  int  nfr = 0, cur_len = 0, sl_cnt = 0;
  logic [63:0] acc = '0;
  bit  prev_bclk = 0, started = 0, in_frame = 0, prev_ws = 0, cur_ws = 0, slave_drive = 0;

  always @(negedge clk) begin
    if (bclk_o && !prev_bclk) begin
      if (!started) begin
        started = 1; prev_ws = ws_o;
      end else if (ws_o != prev_ws) begin
        if (in_frame && nfr < 32) begin
          fr_bits[nfr] = {acc[62:0], sd_o};
          fr_len[nfr]  = cur_len + 1;
          fr_ws[nfr]   = cur_ws;
          nfr++;
        end
        in_frame = 1; acc = '0; cur_len = 0; prev_ws = ws_o; cur_ws = ws_o;
      end else if (in_frame) begin
        acc = {acc[62:0], sd_o}; cur_len++;
      end
      if (slave_drive) begin
        sl_cnt++;
        if (sl_cnt == 24) begin ws_i = ~ws_i; sl_cnt = 0; end
      end
    end
    prev_bclk = bclk_o;
  end

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] fexp(logic [31:0] d, logic [1:0] wc, int h);
    int w;
    logic [63:0] v;
    w = (wc == 2'b00) ? 8 : (wc == 2'b01) ? 16 : 32;
    v = {32'h0, d} & ((64'd1 << w) - 64'd1);
    if (h >= w) return v << (h - w);
    return v >> (w - h);
  endfunction

  task automatic do_reset();
    rst_n = 1'b0;
    @(posedge clk);
    nfr = 0; started = 0; in_frame = 0; prev_bclk = 0; sl_cnt = 0;
    q_head = 0; pend = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_frames(int n, string req);
    int t = 0;
    while (nfr < n && t < 30000) begin @(posedge clk); t++; end
    chk(nfr >= n, req, "frames received", nfr, n);
  endtask

  task automatic set_cfg(logic [1:0] w, bit mono, bit stop, bit slave, bit mute, int hp);
    cfg_width = w; cfg_mono = mono; cfg_stop = stop; cfg_slave = slave;
    cfg_mute = mute; cfg_half_period = 9'(hp);
  endtask

  task automatic load_q(int n, logic [31:0] base);
    for (int i = 0; i < n; i++) q_mem[i] = base ^ (32'h1357_9BDF * (i + 1));
    q_cnt = n;
  endtask

  task automatic t_reset();
    set_cfg(2'b01, 0, 0, 1, 1, 31);
    q_cnt = 0;
    do_reset();
    @(negedge clk);
    chk(bclk_o == 0, "R11", "bclk after reset", bclk_o, 0);
    chk(sd_o == 0, "R11", "sd after reset", sd_o, 0);
    chk(s_ready == 0, "R11", "ready after reset", s_ready, 0);
    chk(underrun == 0, "R11", "underrun after reset", underrun, 0);
    chk(ws_o == 1, "R11", "ws after reset", ws_o, 1);
    chk(ws_oe == 0, "R11", "ws_oe in slave", ws_oe, 0);
  endtask

  task automatic t_master_stereo16();
    set_cfg(2'b01, 0, 0, 0, 0, 31);
    load_q(8, 32'hBEEF_A5C3);
    do_reset();
    wait_frames(6, "R3");
    chk(ws_oe == 1, "R4", "ws_oe in master", ws_oe, 1);
    for (int i = 0; i < 6; i++) begin
      chk(fr_len[i] == 32, "R4", "half frame length", fr_len[i], 32);
      chk(fr_ws[i] == i[0], "R3", "channel order", fr_ws[i], i[0]);
      chk(fr_bits[i] == fexp(q_mem[i], 2'b01, 32), "R2", "stereo 16-bit word",
          fr_bits[i], fexp(q_mem[i], 2'b01, 32));
    end
  endtask

  task automatic t_mono8();
    set_cfg(2'b00, 1, 0, 0, 0, 15);
    load_q(4, 32'hABCD_12A5);
    do_reset();
    wait_frames(6, "R3");
    for (int i = 0; i < 6; i++) begin
      chk(fr_len[i] == 16, "R4", "mono half frame length", fr_len[i], 16);
      chk(fr_bits[i] == fexp(q_mem[i/2], 2'b00, 16), "R1", "mono 8-bit word",
          fr_bits[i], fexp(q_mem[i/2], 2'b00, 16));
    end
  endtask

  task automatic t_wide32();
    set_cfg(2'b10, 0, 0, 0, 0, 31);
    load_q(6, 32'h8123_4567);
    do_reset();
    wait_frames(4, "R1");
    for (int i = 0; i < 4; i++)
      chk(fr_bits[i] == {32'h0, q_mem[i]}, "R1", "code 10 as 32-bit", fr_bits[i], {32'h0, q_mem[i]});
  endtask

  task automatic t_trunc();
    set_cfg(2'b01, 0, 0, 0, 0, 7);
    load_q(6, 32'h0000_C3A5);
    do_reset();
    wait_frames(4, "R2");
    for (int i = 0; i < 4; i++) begin
      chk(fr_len[i] == 8, "R4", "short half frame", fr_len[i], 8);
      chk(fr_bits[i] == fexp(q_mem[i], 2'b01, 8), "R2", "truncated word",
          fr_bits[i], fexp(q_mem[i], 2'b01, 8));
    end
  endtask

  task automatic t_mute();
    set_cfg(2'b01, 0, 0, 0, 1, 15);
    load_q(10, 32'hFFFF_FFFF);
    do_reset();
    wait_frames(6, "R6");
    for (int i = 0; i < 6; i++)
      chk(fr_bits[i] == 0, "R6", "muted frame", fr_bits[i], 0);
    chk(q_head >= 5, "R6", "words still taken while muted", q_head, 5);
    chk(underrun == 0, "R6", "no underrun while muted", underrun, 0);
  endtask

  task automatic t_stop();
    set_cfg(2'b01, 0, 1, 0, 0, 15);
    load_q(6, 32'hFFFF_FFFF);
    do_reset();
    wait_frames(4, "R7");
    for (int i = 0; i < 4; i++)
      chk(fr_bits[i] == 0, "R7", "stopped frame", fr_bits[i], 0);
    chk(q_head == 0 && !pend, "R7", "no words taken while stopped", q_head, 0);
    chk(underrun == 0, "R7", "no underrun while stopped", underrun, 0);
  endtask

  task automatic t_underrun();
    int base;
    set_cfg(2'b01, 0, 0, 0, 0, 15);
    q_cnt = 0;
    do_reset();
    wait_frames(3, "R8");
    chk(fr_bits[0] == 0, "R8", "empty frame is zero", fr_bits[0], 0);
    chk(underrun == 1, "R8", "underrun set", underrun, 1);
    @(posedge clk);
    load_q(8, 32'h0000_7E81);
    base = nfr;
    wait_frames(base + 4, "R8");
    chk(underrun == 1, "R8", "underrun sticky after data", underrun, 1);
    @(negedge clk);
    cfg_soft_rst = 1'b1;
    #1;
    chk(underrun == 0, "R9", "soft reset clears underrun", underrun, 0);
    chk(fifo_flush == 1, "R9", "flush during soft reset", fifo_flush, 1);
    chk(bclk_o == 0 && sd_o == 0, "R9", "bclk and sd cleared", {bclk_o, sd_o}, 0);
    @(negedge clk);
    cfg_soft_rst = 1'b0;
    #1;
    chk(fifo_flush == 0, "R9", "flush released", fifo_flush, 0);
    chk(s_ready == 0, "R9", "ready idle after soft reset", s_ready, 0);
  endtask

  task automatic t_slave();
    set_cfg(2'b01, 0, 0, 1, 0, 5);
    load_q(8, 32'h5A5A_0F0F);
    ws_i = 1'b1;
    slave_drive = 1;
    do_reset();
    wait_frames(5, "R5");
    chk(ws_oe == 0, "R5", "ws_oe in slave", ws_oe, 0);
    for (int i = 0; i < 4; i++) begin
      chk(fr_len[i] == 24, "R5", "half frame follows ws_i", fr_len[i], 24);
      chk(fr_ws[i] == i[0], "R5", "slave channel order", fr_ws[i], i[0]);
      chk(fr_bits[i] == fexp(q_mem[i], 2'b01, 24), "R5", "slave word",
          fr_bits[i], fexp(q_mem[i], 2'b01, 24));
    end
    slave_drive = 0;
  endtask

  // R10: the offer lasts a single cycle
  int rdy_run = 0;
  always @(negedge clk) begin
    if (rst_n && s_ready) begin
      rdy_run++;
      if (rdy_run > 1) chk(0, "R10", "ready longer than one cycle", rdy_run, 1);
    end else rdy_run = 0;
  end

  initial begin
    t_reset();
    t_master_stereo16();
    t_mono8();
    t_wide32();
    t_trunc();
    t_mute();
    t_stop();
    t_underrun();
    t_slave();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog run did not finish actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule